// File: doc/BRIEF.md
# Store-and-Forward Transmit Packet Gate

This block sits in front of a 256-bit Ethernet MAC transmit stream. The upstream producer hands over 32-byte words tagged with start, end, unused-byte count and an error marker, and it may pause in the middle of a packet. The gate writes every word into an internal word buffer. It offers a packet to the MAC only after the last word of that packet has been stored. From then on the MAC sees the packet as one unbroken run of valid beats, even though the producer delivered it with gaps.

A length tracker counts the words of the packet that is being written. From that count and the final unused-byte value it works out the byte length of the packet. A packet shorter than nine bytes is thrown away by moving the write pointer back to the first word of that packet. A packet longer than the buffer can ever hold is thrown away in the same way, its remaining words are swallowed, and a sticky overflow flag is raised. No packet is started toward the MAC until the link lanes report stable. One clock drives the whole block, and the transfer rule is ready-latency zero: a beat moves in every cycle where valid and ready are both high.

Top module: `sfTxGate`

## Requirements
- R1: After reset, outValid is low, inReady is high and ovfFlag is low.
- R2: Packets that are kept come out in arrival order, and each word carries its input data unchanged. outSop is high only on the first word of a packet and outEop only on its last word.
- R3: Once the first beat of a packet has been presented, outValid stays high on every cycle until the end-of-packet beat has been transferred, even if the producer paused while writing that packet.
- R4: While outValid is high and outReady is low, the next cycle shows the same beat: outData, outSop, outEop, outEmpty and outErr are all unchanged.
- R5: No word of a packet is presented before that packet's end-of-packet word has been accepted at the input. Once it has been accepted, and lanesStable is high and the output is idle, the first word is presented in the cycle that follows the accepting edge.
- R6: While lanesStable is low, no new packet is started and stored packets are kept. When lanesStable rises, the oldest stored packet is presented in the following cycle.
- R7: Packet length in bytes is 32 × words − inEmpty, where inEmpty is the number of unused bytes in the final word, counted from the least significant lane. A packet shorter than 9 bytes never reaches the output. A one-word packet with inEmpty = 23 is 9 bytes and is delivered. With inEmpty = 24 it is 8 bytes and is dropped.
- R8: outErr equals the inErr value of the end-of-packet word and is high only on an end-of-packet beat. inErr on any other word has no effect.
- R9: outEmpty equals the inEmpty value of the end-of-packet word on that beat and is zero on all other beats.
- R10: With 64 words stored (the default DEPTH), inReady is low. A packet of more than 63 words is dropped whole, its remaining input words are accepted and discarded, and ovfFlag goes high on the cycle after the word that overflows. ovfFlag then stays high until reset, and later packets are delivered normally.
- R11: A word accepted while no packet is open and with inSop low is discarded and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rstN | input | 1 | Asynchronous active-low reset |
| lanesStable | input | 1 | Link lanes stable; new packets start only while high |
| inValid | input | 1 | Producer word valid |
| inReady | output | 1 | Gate can accept a word this cycle |
| inData | input | 256 | Producer word, first byte in the most significant lane |
| inSop | input | 1 | First word of a packet |
| inEop | input | 1 | Last word of a packet |
| inEmpty | input | 5 | Unused bytes in the last word |
| inErr | input | 1 | Corrupt-frame request, honoured on the last word |
| outValid | output | 1 | Beat valid toward the MAC |
| outReady | input | 1 | MAC accepts the beat this cycle |
| outData | output | 256 | Beat data |
| outSop | output | 1 | First beat of a packet |
| outEop | output | 1 | Last beat of a packet |
| outEmpty | output | 5 | Unused bytes on the last beat, zero otherwise |
| outErr | output | 1 | Corrupt-frame request on the last beat |
| ovfFlag | output | 1 | Sticky flag: a packet larger than the buffer was dropped |

## Verification
The output side has no pipeline register. A packet whose end word is accepted at one rising edge, or whose lanesStable rise comes before a rising edge, is presented in the cycle after that edge. inReady and ovfFlag change in the cycle after the edge that accepts the word responsible. The bench therefore drives inputs just after a rising edge and reads outputs at the following falling edge, where the values for that cycle have settled and show what the next rising edge will transfer. A monitor running at each falling edge compares every beat that will transfer against the expected stream, and it checks the hold and no-gap rules against the value it saw one falling edge earlier.

// File: rtl/sfGatePkg.sv
package sfGatePkg;

  // Strobes from the control block to the buffer datapath, one cycle each.
  typedef struct packed {
    logic push;    // write the input word at the write pointer and advance it
    logic commit;  // the pushed word ends a packet: move the packet base past it
    logic rewind;  // discard the open packet: write pointer back to packet base
    logic pop;     // output beat transferred: advance the read pointer
  } bufStrobe_t;

endpackage

// File: rtl/sfGateBuf.sv
module sfGateBuf
  import sfGatePkg::*;
#(
  parameter int DATA_W  = 256,
  parameter int EMPTY_W = 5,
  parameter int DEPTH   = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  bufStrobe_t         stb,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [EMPTY_W-1:0] inEmpty,
  input  logic               inErr,
  output logic [PTR_W-1:0]   usedWords,
  output logic [DATA_W-1:0]  outData,
  output logic               outSop,
  output logic               outEop,
  output logic [EMPTY_W-1:0] outEmpty,
  output logic               outErr
);

  localparam int ENT_W = DATA_W + EMPTY_W + 3;

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] basePtr;
  logic [PTR_W-1:0] rdPtr;
  logic [ENT_W-1:0] store [DEPTH];
  logic [ENT_W-1:0] wrEntry;
  logic [ENT_W-1:0] rdEntry;

  // Side fields are masked at write time so that only end words carry them.
  assign wrEntry = {inData, inSop, inEop,
                    (inEop ? inEmpty : {EMPTY_W{1'b0}}),
                    (inEop & inErr)};

  always_ff @(posedge clk) begin
    if (stb.push) store[wrPtr[ADDR_W-1:0]] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      basePtr <= '0;
      rdPtr   <= '0;
    end else begin
      if (stb.rewind)    wrPtr <= basePtr;
      else if (stb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (stb.commit)    basePtr <= wrPtr + PTR_W'(1);
      if (stb.pop)       rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  // Zero-latency read: the head word is on the outputs while it sits in the buffer.
  assign rdEntry   = store[rdPtr[ADDR_W-1:0]];
  assign outData   = rdEntry[ENT_W-1 -: DATA_W];
  assign outSop    = rdEntry[EMPTY_W+2];
  assign outEop    = rdEntry[EMPTY_W+1];
  assign outEmpty  = rdEntry[EMPTY_W:1];
  assign outErr    = rdEntry[0];
  assign usedWords = wrPtr - rdPtr;

endmodule

// File: rtl/sfGateCtrl.sv
module sfGateCtrl
  import sfGatePkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int BYTES     = 32,
  parameter int MIN_BYTES = 9,
  localparam int EMPTY_W  = $clog2(BYTES),
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lanesStable,
  input  logic               inValid,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [EMPTY_W-1:0] inEmpty,
  output logic               inReady,
  input  logic               outReady,
  input  logic               outSop,
  input  logic               outEop,
  output logic               outValid,
  input  logic [CNT_W-1:0]   usedWords,
  output bufStrobe_t         stb,
  output logic               ovfFlag
);

  localparam int MAX_WORDS = DEPTH - 1;
  localparam int BYTE_SH   = $clog2(BYTES);
  localparam int LEN_W     = CNT_W + BYTE_SH + 1;

  logic             pktOpen;
  logic             swallow;
  logic             txActive;
  logic             ovfQ;
  logic [CNT_W-1:0] curWords;
  logic [CNT_W-1:0] pktCount;
  logic [CNT_W-1:0] wordIdx;
  logic [LEN_W-1:0] lenBytes;
  logic             acceptIn;
  logic             beatLive;
  logic             overflowHit;
  logic             runtHit;
  logic             popEop;

  // ---------------- input side: length tracking and drop decisions
  assign inReady     = usedWords < CNT_W'(DEPTH);
  assign acceptIn    = inValid && inReady;
  assign beatLive    = acceptIn && !swallow && (pktOpen || inSop);
  assign wordIdx     = pktOpen ? curWords : '0;
  assign overflowHit = beatLive && (wordIdx == CNT_W'(MAX_WORDS));
  assign lenBytes    = ((LEN_W'(wordIdx) + LEN_W'(1)) << BYTE_SH) - LEN_W'(inEmpty);
  assign runtHit     = beatLive && inEop && !overflowHit &&
                       (lenBytes < LEN_W'(MIN_BYTES));

  always_comb begin
    stb.push   = beatLive && !overflowHit && !runtHit;
    stb.commit = beatLive && !overflowHit && !runtHit && inEop;
    stb.rewind = overflowHit || runtHit;
    stb.pop    = outValid && outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktOpen  <= 1'b0;
      swallow  <= 1'b0;
      curWords <= '0;
      ovfQ     <= 1'b0;
    end else begin
      if (beatLive) begin
        if (overflowHit) begin
          pktOpen  <= 1'b0;
          swallow  <= !inEop;
          curWords <= '0;
        end else if (inEop) begin
          pktOpen  <= 1'b0;
          curWords <= '0;
        end else begin
          pktOpen  <= 1'b1;
          curWords <= wordIdx + CNT_W'(1);
        end
      end else if (acceptIn && swallow && inEop) begin
        swallow <= 1'b0;
      end
      if (overflowHit) ovfQ <= 1'b1;
    end
  end

  assign ovfFlag = ovfQ;

  // ---------------- output side: packet count and gap-free sequencing
  assign popEop   = stb.pop && outEop;
  assign outValid = txActive || ((pktCount != '0) && lanesStable);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktCount <= '0;
      txActive <= 1'b0;
    end else begin
      if (stb.commit && !popEop)      pktCount <= pktCount + CNT_W'(1);
      else if (!stb.commit && popEop) pktCount <= pktCount - CNT_W'(1);
      if (popEop)        txActive <= 1'b0;
      else if (outValid) txActive <= 1'b1;
    end
  end

  AST_SOP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !txActive) |-> outSop); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    usedWords <= CNT_W'(DEPTH)); // R10

endmodule

// File: rtl/sfTxGate.sv
module sfTxGate
  import sfGatePkg::*;
#(
  parameter int DATA_W    = 256,
  parameter int DEPTH     = 64,
  parameter int MIN_BYTES = 9,
  localparam int BYTES    = DATA_W / 8,
  localparam int EMPTY_W  = $clog2(BYTES),
  localparam int CNT_W    = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lanesStable,
  input  logic               inValid,
  output logic               inReady,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [EMPTY_W-1:0] inEmpty,
  input  logic               inErr,
  output logic               outValid,
  input  logic               outReady,
  output logic [DATA_W-1:0]  outData,
  output logic               outSop,
  output logic               outEop,
  output logic [EMPTY_W-1:0] outEmpty,
  output logic               outErr,
  output logic               ovfFlag
);

  bufStrobe_t       stb;
  logic [CNT_W-1:0] usedWords;

  sfGateCtrl #(
    .DEPTH(DEPTH), .BYTES(BYTES), .MIN_BYTES(MIN_BYTES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .lanesStable(lanesStable),
    .inValid(inValid), .inSop(inSop), .inEop(inEop), .inEmpty(inEmpty),
    .inReady(inReady), .outReady(outReady), .outSop(outSop), .outEop(outEop),
    .outValid(outValid), .usedWords(usedWords), .stb(stb), .ovfFlag(ovfFlag)
  );

  sfGateBuf #(
    .DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .DEPTH(DEPTH)
  ) dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inData(inData), .inSop(inSop), .inEop(inEop), .inEmpty(inEmpty), .inErr(inErr),
    .usedWords(usedWords), .outData(outData), .outSop(outSop), .outEop(outEop),
    .outEmpty(outEmpty), .outErr(outErr)
  );

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outEop) |=> outValid); // R3

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSop) &&
      $stable(outEop) && $stable(outEmpty) && $stable(outErr))); // R4

  AST_START_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop && !$past(outValid && !outReady)) |-> lanesStable); // R6

  AST_SIDE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outEop) |-> ((outEmpty == '0) && !outErr)); // R9

endmodule

// File: tb/sfTxGate_test.sv
module sfTxGate_test;

  localparam int DW = 256;
  localparam int QN = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lanesStable = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] inData = '0;
  logic          inSop = 1'b0;
  logic          inEop = 1'b0;
  logic [4:0]    inEmpty = '0;
  logic          inErr = 1'b0;
  logic          outValid;
  logic          outReady;
  logic [DW-1:0] outData;
  logic          outSop;
  logic          outEop;
  logic [4:0]    outEmpty;
  logic          outErr;
  logic          ovfFlag;

  int checks = 0;
  int errors = 0;
  int readyMode = 0;
  int cyc = 0;

  sfTxGate uut (
    .clk(clk), .rstN(rstN), .lanesStable(lanesStable),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSop(inSop),
    .inEop(inEop), .inEmpty(inEmpty), .inErr(inErr),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSop(outSop),
    .outEop(outEop), .outEmpty(outEmpty), .outErr(outErr), .ovfFlag(ovfFlag)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Vector: {words[20:13], empty[12:8], err[7], pause[6:3], readyMode[2:1], keep[0]}
  localparam logic [20:0] VEC [10] = '{
    {8'd1, 5'd0,  1'b0, 4'd0, 2'd0, 1'b1},
    {8'd4, 5'd5,  1'b1, 4'd2, 2'd1, 1'b1},
    {8'd1, 5'd23, 1'b0, 4'd0, 2'd0, 1'b1},
    {8'd1, 5'd24, 1'b1, 4'd0, 2'd0, 1'b0},
    {8'd2, 5'd31, 1'b0, 4'd1, 2'd1, 1'b1},
    {8'd3, 5'd0,  1'b1, 4'd3, 2'd1, 1'b1},
    {8'd1, 5'd31, 1'b0, 4'd0, 2'd0, 1'b0},
    {8'd8, 5'd7,  1'b0, 4'd1, 2'd1, 1'b1},
    {8'd5, 5'd2,  1'b0, 4'd0, 2'd0, 1'b1},
    {8'd2, 5'd16, 1'b1, 4'd0, 2'd1, 1'b1}
  };

  // Expected output stream
  logic [DW-1:0] expData [QN];
  logic          expSop [QN];
  logic          expEop [QN];
  logic [4:0]    expEmpty [QN];
  logic          expErr [QN];
  int expWr = 0;
  int expRd = 0;

  function automatic logic [DW-1:0] mkData(int pid, int w);
    return {8{pid[15:0], w[15:0]}};
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic queuePkt(int pid, int n, int emp, bit er);
    for (int w = 0; w < n; w++) begin
      expData[expWr % QN]  = mkData(pid, w);
      expSop[expWr % QN]   = (w == 0);
      expEop[expWr % QN]   = (w == n - 1);
      expEmpty[expWr % QN] = (w == n - 1) ? emp[4:0] : 5'd0;
      expErr[expWr % QN]   = (w == n - 1) ? er : 1'b0;
      expWr++;
    end
  endtask

  task automatic sendBeat(logic [DW-1:0] d, bit s, bit e, logic [4:0] em, bit er);
    inData = d; inSop = s; inEop = e; inEmpty = em; inErr = er; inValid = 1'b1;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  // Error and empty are driven on every word to show they only count at the end.
  task automatic sendPkt(int pid, int n, int emp, bit er, int pause);
    for (int w = 0; w < n; w++) begin
      sendBeat(mkData(pid, w), (w == 0), (w == n - 1), emp[4:0], er);
      if (w == 0 && n > 1 && pause > 0) begin
        repeat (pause) @(posedge clk);
        #1;
      end
    end
  endtask

  task automatic waitDrain(string tag);
    for (int i = 0; i < 3000 && expRd != expWr; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expRd == expWr, tag, expRd, expWr);
  endtask

  // Output ready pattern: 0 always high, 1 two of three cycles, 2 low
  initial begin
    outReady = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = (cyc % 3) != 0;
        default: outReady = 1'b0;
      endcase
    end
  end

  // Monitor: beat contents, hold under stall, no gaps
  bit            holdPend = 1'b0;
  bit            monInPkt = 1'b0;
  logic [DW-1:0] hData;
  logic [8:0]    hSide;

  always @(negedge clk) begin
    if (rstN) begin
      if (holdPend) begin
        checks++;
        if (!(outValid && outData == hData &&
              {outSop, outEop, outEmpty, outErr, 1'b0} == {hSide[8:1], 1'b0} )) begin
          errors++;
          $display("FAIL R4 hold: actual valid=%0b side=%h expected valid=1 side=%h",
                   outValid, {outSop, outEop, outEmpty, outErr}, hSide[8:1]);
        end
      end
      holdPend = outValid && !outReady;
      hData    = outData;
      hSide    = {outSop, outEop, outEmpty, outErr, 1'b0};
      if (monInPkt && !outValid) begin
        errors++;
        $display("FAIL R3 gap inside packet: actual valid=0 expected valid=1");
      end
      if (outValid && outReady) begin
        if (expRd == expWr) begin
          chk(1'b0, "R11 unexpected beat", 1, 0);
        end else begin
          chk(outData == expData[expRd % QN], "R2 data word", int'(outData[15:0]),
              int'(expData[expRd % QN][15:0]));
          chk({outSop, outEop} == {expSop[expRd % QN], expEop[expRd % QN]},
              "R2 sop/eop", int'({outSop, outEop}),
              int'({expSop[expRd % QN], expEop[expRd % QN]}));
          chk(outEmpty == expEmpty[expRd % QN], "R9 empty", int'(outEmpty),
              int'(expEmpty[expRd % QN]));
          chk(outErr == expErr[expRd % QN], "R8 error", int'(outErr),
              int'(expErr[expRd % QN]));
          expRd++;
        end
        monInPkt = !outEop;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(!outValid, "R1 outValid after reset", int'(outValid), 0);
    chk(inReady, "R1 inReady after reset", int'(inReady), 1);
    chk(!ovfFlag, "R1 ovfFlag after reset", int'(ovfFlag), 0);

    // R6: lanes not yet stable
    @(posedge clk); #1;
    queuePkt(100, 2, 4, 1'b0);
    sendPkt(100, 2, 4, 1'b0, 0);
    repeat (5) @(negedge clk);
    chk(!outValid, "R6 held while lanes unstable", int'(outValid), 0);
    @(posedge clk); #1 lanesStable = 1'b1;
    @(negedge clk);
    chk(outValid && outSop, "R6 start after lanes stable", int'(outValid && outSop), 1);
    waitDrain("R6 drained");

    // Vector table
    for (int i = 0; i < 10; i++) begin
      readyMode = int'(VEC[i][2:1]);
      @(posedge clk); #1;
      if (VEC[i][0])
        queuePkt(i, int'(VEC[i][20:13]), int'(VEC[i][12:8]), VEC[i][7]);
      sendPkt(i, int'(VEC[i][20:13]), int'(VEC[i][12:8]), VEC[i][7], int'(VEC[i][6:3]));
    end
    readyMode = 0;
    waitDrain("R2 table stream delivered");

    // R5: store before forward
    @(posedge clk); #1;
    queuePkt(200, 3, 1, 1'b0);
    sendBeat(mkData(200, 0), 1'b1, 1'b0, 5'd1, 1'b0);
    sendBeat(mkData(200, 1), 1'b0, 1'b0, 5'd1, 1'b0);
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (outValid) seen = 1'b1;
    end
    chk(!seen, "R5 no output before end word", int'(seen), 0);
    @(posedge clk); #1;
    sendBeat(mkData(200, 2), 1'b0, 1'b1, 5'd1, 1'b0);
    @(negedge clk);
    chk(outValid && outSop, "R5 output after end word", int'(outValid && outSop), 1);
    waitDrain("R5 drained");

    // R7: runt boundary
    sendPkt(300, 1, 24, 1'b0, 0);
    repeat (4) @(negedge clk);
    chk(!outValid, "R7 8-byte frame dropped", int'(outValid), 0);
    @(posedge clk); #1;
    queuePkt(301, 1, 23, 1'b1);
    sendPkt(301, 1, 23, 1'b1, 0);
    waitDrain("R7 9-byte frame delivered");

    // R11: words outside a packet
    sendBeat(mkData(400, 0), 1'b0, 1'b0, 5'd0, 1'b0);
    sendBeat(mkData(400, 1), 1'b0, 1'b1, 5'd0, 1'b0);
    repeat (4) @(negedge clk);
    chk(!outValid, "R11 stray words discarded", int'(outValid), 0);
    @(posedge clk); #1;
    queuePkt(401, 2, 0, 1'b0);
    sendPkt(401, 2, 0, 1'b0, 0);
    waitDrain("R11 following packet delivered");

    // R10: full buffer backpressure
    readyMode = 2;
    repeat (2) @(posedge clk); #1;
    for (int p = 0; p < 8; p++) begin
      queuePkt(500 + p, 8, p, 1'b0);
      sendPkt(500 + p, 8, p, 1'b0, 0);
    end
    inData = mkData(600, 0); inSop = 1'b1; inEop = 1'b0; inValid = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (inReady) seen = 1'b1;
    end
    chk(!seen, "R10 inReady low when full", int'(seen), 0);
    @(posedge clk); #1;
    inValid = 1'b0; inSop = 1'b0;
    readyMode = 0;
    waitDrain("R10 full buffer drained");
    chk(!ovfFlag, "R10 no overflow yet", int'(ovfFlag), 0);

    // R10: oversize packet
    @(posedge clk); #1;
    sendPkt(700, 66, 0, 1'b0, 0);
    @(negedge clk);
    chk(ovfFlag, "R10 overflow flag set", int'(ovfFlag), 1);
    chk(!outValid, "R10 oversize packet dropped", int'(outValid), 0);
    @(posedge clk); #1;
    queuePkt(701, 3, 9, 1'b1);
    sendPkt(701, 3, 9, 1'b1, 2);
    waitDrain("R10 packet after overflow delivered");
    chk(ovfFlag, "R10 overflow flag sticky", int'(ovfFlag), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule